// File: doc/BRIEF.md
# Shared-Cache Miss Resource Controller

This block is the miss-handling front end of a shared last-level cache. Several upstream ports present requests that a tag stub has already classified as hit or miss. A miss may also carry a flag for a dirty victim line. Hits complete after a fixed pipeline latency. Misses take an entry in a file of outstanding-miss registers. Dirty victims are parked in a small writeback queue. Refill reads and victim writes leave on one memory request channel, and refill completions come back on a response channel tagged with the miss entry number.

The cache keeps accepting requests, including further misses, while earlier refills are still in flight. If either the miss file or the writeback queue has no free slot, the whole cache stalls: no port is accepted, not even one that would hit. The stall lifts only once both structures have room again. A free-running count of stalled cycles is provided as an output.

Top module: `llc_miss_ctrl`

## Requirements
- R1: An accepted hit presented in cycle c produces a one-cycle pulse on hit_valid_o in cycle c+HIT_LAT, with hit_port_o equal to the accepted port's index.
- R2: A miss whose line has no outstanding entry takes the lowest-numbered free miss entry. Starting in the next cycle, a read request is raised (mem_req_write_o = 0) with that line address and mem_req_id_o equal to the entry number. A response carrying that entry number raises fill_valid_o, with fill_addr_o equal to the line, in the same cycle, and frees the entry.
- R3: Further misses to other lines are accepted while earlier reads are outstanding, until all MSHR_N entries are in use.
- R4: A miss to a line that already holds an outstanding entry is accepted, takes no new entry and causes no memory request. Its dirty flag is ignored.
- R5: A non-merging miss with the dirty flag set causes two memory transactions: the refill read of its line, and a write (mem_req_write_o = 1, mem_req_id_o = 0) of its victim line address. Victims are written in arrival order.
- R6: A pending refill read goes out before any queued victim write, unless the writeback queue is full. In that case the oldest victim write goes out first.
- R7: While all miss entries are in use or the writeback queue is full, blocked_o is 1 and every bit of req_ready_o is 0, for hits and misses alike.
- R8: blocked_o drops only when at least one miss entry and at least one writeback slot are free. A free miss entry alone, with a full queue, keeps it high, and the same holds the other way round.
- R9: At most one port is accepted per cycle. Among ports that request at once, the grant rotates round-robin, starting after the most recently granted port. A port that is not granted sees req_ready_o low and keeps its request presented.
- R10: blocked_cycles_o increments by one at each clock edge that ends a cycle in which blocked_o is 1, and holds otherwise.
- R11: After reset, blocked_o, hit_valid_o, mem_req_valid_o, fill_valid_o, req_ready_o and blocked_cycles_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | NP | Request present, one bit per port |
| req_miss_i | input | NP | 1 = request missed in the tags |
| req_dirty_i | input | NP | 1 = the miss evicts a dirty victim |
| req_line_i | input | NP x AW | Requested line address per port |
| req_victim_i | input | NP x AW | Victim line address per port |
| req_ready_o | output | NP | Request accepted this cycle (one-hot or zero) |
| blocked_o | output | 1 | Cache-wide stall |
| hit_valid_o | output | 1 | Hit completion pulse |
| hit_port_o | output | PW | Port of the completing hit |
| mem_req_valid_o | output | 1 | Memory request present |
| mem_req_write_o | output | 1 | 0 = refill read, 1 = victim write |
| mem_req_addr_o | output | AW | Line address of the memory request |
| mem_req_id_o | output | IW | Miss entry of a read, 0 for writes |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_rsp_valid_i | input | 1 | Refill returned |
| mem_rsp_id_i | input | IW | Miss entry of the returned refill |
| fill_valid_o | output | 1 | Refill completed for a live entry |
| fill_addr_o | output | AW | Line of the completed refill |
| blocked_cycles_o | output | CNT_W | Count of stalled cycles |

## Verification
Timing is counted from the cycle in which a request is presented with its ready high. The hit pulse is due exactly HIT_LAT cycles later. The refill read is visible from the next cycle on. The stall shows in the cycle after the accept that used up the last slot. A refill completion shows in the same cycle as its response. The bench keeps a cycle number and samples every output a few time units after the falling edge. It records the due cycle of each hit in a queue, and a monitor compares every hit pulse against that queue. The expected order of memory transactions is kept in a second queue, and the monitor pops it on each handshake. The stall counter is read at two falling edges a known number of cycles apart.

// File: rtl/llc_miss_pkg.sv
package llc_miss_pkg;
  typedef enum logic {
    MEM_RD = 1'b0,
    MEM_WR = 1'b1
  } mem_op_e;
endpackage

// File: rtl/llc_rr_arb.sv
module llc_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         en_i,
  output logic [N-1:0] gnt_o
);
  logic [IW-1:0] last_q;
  logic [IW-1:0] gnt_idx;

  always_comb begin
    int idx;
    logic found;
    gnt_o   = '0;
    gnt_idx = last_q;
    found   = 1'b0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last_q) + k) % N;
      if (en_i && !found && req_i[idx]) begin
        gnt_o[idx] = 1'b1;
        gnt_idx    = IW'(idx);
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= IW'(N - 1);
    else if (|gnt_o) last_q <= gnt_idx;
  end

  // R9: single acceptance per cycle
  a_r9_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(gnt_o));
endmodule

// File: rtl/llc_mshr_file.sv
module llc_mshr_file #(
  parameter int N  = 24,
  parameter int AW = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] lookup_line_i,
  output logic          merge_o,
  output logic          full_o,
  input  logic          alloc_i,
  output logic          rd_pend_o,
  output logic [IW-1:0] rd_idx_o,
  output logic [AW-1:0] rd_line_o,
  input  logic          rd_issue_i,
  input  logic          rsp_valid_i,
  input  logic [IW-1:0] rsp_id_i,
  output logic          rsp_known_o,
  output logic [AW-1:0] rsp_line_o
);
  logic [N-1:0]         vld_q, iss_q;
  logic [N-1:0][AW-1:0] line_q;
  logic [IW-1:0]        free_idx;

  always_comb begin
    merge_o     = 1'b0;
    full_o      = &vld_q;
    free_idx    = '0;
    rd_pend_o   = 1'b0;
    rd_idx_o    = '0;
    rd_line_o   = '0;
    rsp_known_o = 1'b0;
    rsp_line_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_idx = IW'(i);
      if (vld_q[i] && !iss_q[i]) begin
        rd_pend_o = 1'b1;
        rd_idx_o  = IW'(i);
        rd_line_o = line_q[i];
      end
    end
    for (int i = 0; i < N; i++) begin
      if (vld_q[i] && line_q[i] == lookup_line_i) merge_o = 1'b1;
      if (vld_q[i] && rsp_id_i == IW'(i)) begin
        rsp_known_o = 1'b1;
        rsp_line_o  = line_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      iss_q  <= '0;
      line_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (alloc_i && free_idx == IW'(i)) begin
          vld_q[i]  <= 1'b1;
          iss_q[i]  <= 1'b0;
          line_q[i] <= lookup_line_i;
        end
        if (rd_issue_i && rd_idx_o == IW'(i)) iss_q[i] <= 1'b1;
        if (rsp_valid_i && rsp_known_o && rsp_id_i == IW'(i)) vld_q[i] <= 1'b0;
      end
    end
  end

  // R7: never allocate into a full file
  a_r7_no_alloc_full: assert property (@(posedge clk_i) disable iff (!rst_ni) alloc_i |-> !full_o);
  // R4: duplicate lines never get a second entry
  a_r4_no_dup_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni) alloc_i |-> !merge_o);
  // R2: a freed entry no longer answers a response
  a_r2_rsp_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && rsp_known_o && !alloc_i) |=> (!rsp_known_o || rsp_id_i != $past(rsp_id_i)));
endmodule

// File: rtl/llc_wb_fifo.sv
module llc_wb_fifo #(
  parameter int D  = 8,
  parameter int AW = 32,
  localparam int PW = (D > 1) ? $clog2(D) : 1,
  localparam int CW = $clog2(D + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_line_i,
  input  logic          pop_i,
  output logic [AW-1:0] head_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [D-1:0][AW-1:0] mem_q;
  logic [PW-1:0]        wr_q, rd_q;
  logic [CW-1:0]        cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(D - 1)) ? '0 : p + PW'(1);
  endfunction

  assign head_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(D));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= push_line_i;
        wr_q        <= bump(wr_q);
      end
      if (pop_i) rd_q <= bump(rd_q);
      if (push_i && !pop_i) cnt_q <= cnt_q + CW'(1);
      else if (pop_i && !push_i) cnt_q <= cnt_q - CW'(1);
    end
  end

  // R7: no push into a full queue
  a_r7_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni) push_i |-> !full_o);
  // R5: no write drawn from an empty queue
  a_r5_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni) pop_i |-> !empty_o);
endmodule

// File: rtl/llc_miss_ctrl.sv
module llc_miss_ctrl
  import llc_miss_pkg::*;
#(
  parameter int NP      = 4,
  parameter int AW      = 32,
  parameter int MSHR_N  = 24,
  parameter int WB_N    = 8,
  parameter int HIT_LAT = 12,
  parameter int CNT_W   = 32,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1,
  localparam int IW = (MSHR_N > 1) ? $clog2(MSHR_N) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NP-1:0]          req_valid_i,
  input  logic [NP-1:0]          req_miss_i,
  input  logic [NP-1:0]          req_dirty_i,
  input  logic [NP-1:0][AW-1:0]  req_line_i,
  input  logic [NP-1:0][AW-1:0]  req_victim_i,
  output logic [NP-1:0]          req_ready_o,
  output logic                   blocked_o,
  output logic                   hit_valid_o,
  output logic [PW-1:0]          hit_port_o,
  output logic                   mem_req_valid_o,
  output logic                   mem_req_write_o,
  output logic [AW-1:0]          mem_req_addr_o,
  output logic [IW-1:0]          mem_req_id_o,
  input  logic                   mem_req_ready_i,
  input  logic                   mem_rsp_valid_i,
  input  logic [IW-1:0]          mem_rsp_id_i,
  output logic                   fill_valid_o,
  output logic [AW-1:0]          fill_addr_o,
  output logic [CNT_W-1:0]       blocked_cycles_o
);
  logic [NP-1:0] gnt;
  logic          accept, sel_miss, sel_dirty;
  logic [AW-1:0] sel_line, sel_victim;
  logic [PW-1:0] sel_port;
  logic          mshr_full, merge, alloc, rd_pend, rd_issue, rsp_known;
  logic [IW-1:0] rd_idx;
  logic [AW-1:0] rd_line, rsp_line, wb_head;
  logic          wb_push, wb_pop, wb_empty, wb_full;
  logic          rd_sel, wr_sel, mem_fire;
  mem_op_e       op;
  logic [CNT_W-1:0] blk_cnt_q;

  assign blocked_o = mshr_full | wb_full;

  llc_rr_arb #(.N(NP)) u_arb (
    .clk_i (clk_i), .rst_ni(rst_ni), .req_i(req_valid_i), .en_i(!blocked_o), .gnt_o(gnt)
  );
  assign req_ready_o = gnt;
  assign accept      = |gnt;

  always_comb begin
    sel_miss   = 1'b0;
    sel_dirty  = 1'b0;
    sel_line   = '0;
    sel_victim = '0;
    sel_port   = '0;
    for (int p = 0; p < NP; p++) begin
      if (gnt[p]) begin
        sel_miss   = req_miss_i[p];
        sel_dirty  = req_dirty_i[p];
        sel_line   = req_line_i[p];
        sel_victim = req_victim_i[p];
        sel_port   = PW'(p);
      end
    end
  end

  assign alloc   = accept && sel_miss && !merge;
  assign wb_push = alloc && sel_dirty;

  llc_mshr_file #(.N(MSHR_N), .AW(AW)) u_mshr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lookup_line_i(sel_line), .merge_o(merge), .full_o(mshr_full), .alloc_i(alloc),
    .rd_pend_o(rd_pend), .rd_idx_o(rd_idx), .rd_line_o(rd_line), .rd_issue_i(rd_issue),
    .rsp_valid_i(mem_rsp_valid_i), .rsp_id_i(mem_rsp_id_i),
    .rsp_known_o(rsp_known), .rsp_line_o(rsp_line)
  );

  llc_wb_fifo #(.D(WB_N), .AW(AW)) u_wb (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(wb_push), .push_line_i(sel_victim), .pop_i(wb_pop),
    .head_o(wb_head), .empty_o(wb_empty), .full_o(wb_full)
  );

  // reads first; a full queue forces a drain so the stall can clear
  assign rd_sel          = rd_pend && !wb_full;
  assign wr_sel          = !rd_sel && !wb_empty;
  assign op              = rd_sel ? MEM_RD : MEM_WR;
  assign mem_req_valid_o = rd_sel || wr_sel;
  assign mem_req_write_o = (op == MEM_WR);
  assign mem_req_addr_o  = rd_sel ? rd_line : wb_head;
  assign mem_req_id_o    = rd_sel ? rd_idx : '0;
  assign mem_fire        = mem_req_valid_o && mem_req_ready_i;
  assign rd_issue        = mem_fire && rd_sel;
  assign wb_pop          = mem_fire && wr_sel;

  assign fill_valid_o = mem_rsp_valid_i && rsp_known;
  assign fill_addr_o  = rsp_line;

  logic [HIT_LAT-1:0]         hv_q;
  logic [HIT_LAT-1:0][PW-1:0] hp_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hv_q <= '0;
      hp_q <= '0;
    end else begin
      hv_q[0] <= accept && !sel_miss;
      hp_q[0] <= sel_port;
      for (int s = 1; s < HIT_LAT; s++) begin
        hv_q[s] <= hv_q[s-1];
        hp_q[s] <= hp_q[s-1];
      end
    end
  end
  assign hit_valid_o = hv_q[HIT_LAT-1];
  assign hit_port_o  = hp_q[HIT_LAT-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) blk_cnt_q <= '0;
    else if (blocked_o) blk_cnt_q <= blk_cnt_q + CNT_W'(1);
  end
  assign blocked_cycles_o = blk_cnt_q;

  // R7: stall covers every port
  a_r7_stall_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked_o |-> (req_ready_o == '0));
  // R10: counter advances across each stalled cycle
  a_r10_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked_o |=> (blocked_cycles_o == $past(blocked_cycles_o) + CNT_W'(1)));
  // R6: a write only overtakes a pending read when the queue is full
  a_r6_read_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_write_o) |-> (!rd_pend || wb_full));
  // R8: a stall cannot clear while the queue stays full
  a_r8_hold_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_full && !wb_pop) |=> blocked_o);
endmodule

// File: tb/llc_miss_ctrl_bench.sv
module llc_miss_ctrl_bench;
  localparam int NP = 2, AW = 8, MSHR_N = 4, WB_N = 2, HIT_LAT = 3, CNT_W = 16;
  localparam int PW = 1, IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NP-1:0] req_valid = '0, req_miss = '0, req_dirty = '0, req_ready;
  logic [NP-1:0][AW-1:0] req_line = '0, req_victim = '0;
  logic blocked, hit_valid, mem_valid, mem_write, fill_valid;
  logic [PW-1:0] hit_port;
  logic [AW-1:0] mem_addr, fill_addr;
  logic [IW-1:0] mem_id;
  logic mem_rdy = 1'b0, rsp_valid = 1'b0;
  logic [IW-1:0] rsp_id = '0;
  logic [CNT_W-1:0] blk_cnt;

  llc_miss_ctrl #(.NP(NP), .AW(AW), .MSHR_N(MSHR_N), .WB_N(WB_N), .HIT_LAT(HIT_LAT), .CNT_W(CNT_W))
  u_llc_miss_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_miss_i(req_miss), .req_dirty_i(req_dirty),
    .req_line_i(req_line), .req_victim_i(req_victim), .req_ready_o(req_ready),
    .blocked_o(blocked), .hit_valid_o(hit_valid), .hit_port_o(hit_port),
    .mem_req_valid_o(mem_valid), .mem_req_write_o(mem_write), .mem_req_addr_o(mem_addr),
    .mem_req_id_o(mem_id), .mem_req_ready_i(mem_rdy),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_id_i(rsp_id),
    .fill_valid_o(fill_valid), .fill_addr_o(fill_addr), .blocked_cycles_o(blk_cnt)
  );

  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    exp_hit_port[$], exp_hit_cyc[$];
  int    exp_mem_wr[$], exp_mem_addr[$], exp_mem_id[$];
  string exp_mem_tag[$];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic expect_mem(input int wr, input int addr, input int id, input string tag);
    exp_mem_wr.push_back(wr); exp_mem_addr.push_back(addr);
    exp_mem_id.push_back(id); exp_mem_tag.push_back(tag);
  endtask

  task automatic issue(input int p, input bit miss, input bit dirty, input int line, input int vic);
    @(negedge clk);
    req_valid[p] = 1'b1; req_miss[p] = miss; req_dirty[p] = dirty;
    req_line[p] = AW'(line); req_victim[p] = AW'(vic);
    #1;
    while (!req_ready[p]) begin @(negedge clk); #1; end
    if (!miss) begin exp_hit_port.push_back(p); exp_hit_cyc.push_back(cyc + HIT_LAT); end
    @(posedge clk); #1 req_valid[p] = 1'b0;
  endtask

  task automatic respond(input int id, input int line);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_id = IW'(id);
    #1 check(fill_valid && fill_addr == AW'(line), "R2", "fill on response", int'(fill_addr), line);
    @(posedge clk); #1 rsp_valid = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: memory handshakes and hit pulses against the scoreboards
  initial forever begin
    @(negedge clk); #2;
    if (rst_n && mem_valid && mem_rdy) begin
      if (exp_mem_wr.size() == 0) check(0, "R4", "unexpected memory request", int'(mem_addr), -1);
      else begin
        automatic int w = exp_mem_wr.pop_front();
        automatic int a = exp_mem_addr.pop_front();
        automatic int i = exp_mem_id.pop_front();
        automatic string t = exp_mem_tag.pop_front();
        check(int'(mem_write) == w, t, "memory op", int'(mem_write), w);
        check(int'(mem_addr) == a, t, "memory address", int'(mem_addr), a);
        check(int'(mem_id) == i, t, "memory id", int'(mem_id), i);
      end
    end
    if (rst_n && hit_valid) begin
      if (exp_hit_cyc.size() == 0) check(0, "R1", "unexpected hit pulse", int'(hit_port), -1);
      else begin
        automatic int hp = exp_hit_port.pop_front();
        automatic int hc = exp_hit_cyc.pop_front();
        check(cyc == hc, "R1", "hit pulse cycle", cyc, hc);
        check(int'(hit_port) == hp, "R1", "hit port", int'(hit_port), hp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(0, "R1", "watchdog expired", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] g1, g2;
    int c0;
    repeat (3) @(negedge clk);
    #1;
    check(!blocked && !hit_valid && !mem_valid && !fill_valid && req_ready == '0 && blk_cnt == '0,
          "R11", "reset state", int'(blocked) + int'(mem_valid) + int'(blk_cnt), 0);
    rst_n = 1'b1;

    // R1: hits on each port
    issue(0, 0, 0, 8'h05, 0);
    issue(1, 0, 0, 8'h06, 0);
    wait_cycles(HIT_LAT + 2);

    // R2: clean miss, read in the following cycle, then fill
    issue(0, 1, 0, 8'h10, 0);
    expect_mem(0, 8'h10, 0, "R2");
    #1 check(mem_valid && !mem_write, "R2", "read raised next cycle", int'(mem_valid), 1);
    mem_rdy = 1'b1;
    wait_cycles(2);
    respond(0, 8'h10);

    // R3 and R4: overlapping misses and a merge
    @(negedge clk); mem_rdy = 1'b0;
    issue(0, 1, 0, 8'h20, 0);
    issue(1, 1, 0, 8'h21, 0);
    #1 check(!blocked, "R3", "second outstanding miss accepted, no stall", int'(blocked), 0);
    issue(0, 1, 1, 8'h20, 8'hEE); // merges: no read, dirty flag ignored
    expect_mem(0, 8'h20, 0, "R4");
    expect_mem(0, 8'h21, 1, "R3");
    @(negedge clk); mem_rdy = 1'b1;
    wait_cycles(6);
    check(exp_mem_wr.size() == 0, "R4", "merged miss adds no traffic", exp_mem_wr.size(), 0);
    respond(0, 8'h20);
    respond(1, 8'h21);

    // R5 and R6: dirty miss gives read then victim write
    @(negedge clk); mem_rdy = 1'b0;
    issue(1, 1, 1, 8'h30, 8'h90);
    expect_mem(0, 8'h30, 0, "R6");
    expect_mem(1, 8'h90, 0, "R5");
    @(negedge clk); mem_rdy = 1'b1;
    wait_cycles(5);
    check(exp_mem_wr.size() == 0, "R5", "read and write both issued", exp_mem_wr.size(), 0);
    respond(0, 8'h30);

    // R7, R8, R10, R6: fill the writeback queue
    @(negedge clk); mem_rdy = 1'b0;
    issue(0, 1, 1, 8'h40, 8'hA0);
    issue(0, 1, 1, 8'h41, 8'hA1);
    expect_mem(1, 8'hA0, 0, "R6");
    expect_mem(0, 8'h40, 0, "R6");
    expect_mem(0, 8'h41, 1, "R6");
    expect_mem(1, 8'hA1, 0, "R5");
    fork
      issue(1, 0, 0, 8'h07, 0);
      begin
        @(negedge clk); #1;
        check(blocked, "R7", "stall on full queue", int'(blocked), 1);
        check(req_ready == '0, "R7", "hit held off while stalled", int'(req_ready), 0);
        check(blocked, "R8", "free miss entries alone do not release", int'(blocked), 1);
        c0 = int'(blk_cnt);
        wait_cycles(5); #1;
        check(int'(blk_cnt) == c0 + 5, "R10", "stall cycle count", int'(blk_cnt), c0 + 5);
        check(!hit_valid && req_ready == '0, "R7", "no hit while stalled", int'(hit_valid), 0);
        mem_rdy = 1'b1;
      end
    join
    wait_cycles(8);
    check(exp_mem_wr.size() == 0, "R6", "drain order complete", exp_mem_wr.size(), 0);
    respond(0, 8'h40);
    respond(1, 8'h41);

    // R7, R8: fill every miss entry
    @(negedge clk); mem_rdy = 1'b0;
    for (int k = 0; k < MSHR_N; k++) begin
      issue(k % NP, 1, 0, 8'h50 + k, 0);
      expect_mem(0, 8'h50 + k, k, "R3");
    end
    #1 check(blocked, "R7", "stall on full miss file", int'(blocked), 1);
    @(negedge clk); mem_rdy = 1'b1;
    wait_cycles(6); #1;
    check(blocked, "R8", "stall holds until an entry frees", int'(blocked), 1);
    respond(2, 8'h52);
    @(negedge clk); #1;
    check(!blocked, "R8", "stall released once both have room", int'(blocked), 0);
    respond(0, 8'h50);
    respond(1, 8'h51);
    respond(3, 8'h53);

    // R9: two ports contend
    @(negedge clk);
    req_valid = '1; req_miss = '0; req_dirty = '0;
    req_line[0] = 8'h61; req_line[1] = 8'h62;
    #1 g1 = req_ready;
    check($countones(g1) == 1, "R9", "single grant", int'(g1), 1);
    for (int p = 0; p < NP; p++)
      if (g1[p]) begin exp_hit_port.push_back(p); exp_hit_cyc.push_back(cyc + HIT_LAT); end
    @(negedge clk); #1 g2 = req_ready;
    check(g2 == ~g1, "R9", "grant rotates to other port", int'(g2), int'(~g1));
    for (int p = 0; p < NP; p++)
      if (g2[p]) begin exp_hit_port.push_back(p); exp_hit_cyc.push_back(cyc + HIT_LAT); end
    @(posedge clk); #1 req_valid = '0;
    wait_cycles(HIT_LAT + 3);
    check(exp_hit_cyc.size() == 0, "R1", "all hits completed", exp_hit_cyc.size(), 0);
    check(exp_mem_wr.size() == 0, "R2", "memory scoreboard empty", exp_mem_wr.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule